// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block sits between the analog comparators of a multi-channel half-bridge motor driver and its gate sequencer. It receives raw digital flags for overcurrent, low-side underload, thermal warning and thermal shutdown on every bridge, plus undervoltage and overvoltage of the power supply. It resynchronizes every flag, qualifies the ones that need a persistence delay, holds the faults that must stay latched, and drives per-bridge latch-off requests and one global lockout to the sequencer.

It also produces the global fault bits that the serial port loads into its status word. Latched faults are cleared by a status-reset request carried in a completed serial frame, by the enable pin going low, or by reset. A status-reset request that follows the previous frame too closely is dropped. Overvoltage lockout can be disabled by a command bit; undervoltage lockout cannot.

Top module: `mdrv_fault_supervisor`

## Requirements
- R1: Bit i of every per-bridge vector belongs to bridge i. A synchronized overcurrent flag held high for OC_QUAL_CYC consecutive cycles sets `bridge_off[i]` and `stat_oc`; a shorter pulse sets neither.
- R2: One shared timer of UL_DELAY_CYC cycles serves all low-side underload flags; a bridge whose underload starts while the timer already runs waits only the remaining time, and at expiry `stat_ul` latches to 1.
- R3: When no bridge reports underload the shared timer stops and reloads, so a new underload waits the full UL_DELAY_CYC.
- R4: At timer expiry, with `ul_shut_en` = 1 every bridge then in underload is latched off; with `ul_shut_en` = 0 `bridge_off` is unchanged.
- R5: `stat_tw` is 1 while any bridge reports thermal warning and returns to 0 by itself; a warning never sets `bridge_off`.
- R6: A thermal shutdown flag latches that bridge off and sets `stat_tsd` at once; a status reset only clears it once the flag is gone.
- R7: `stat_psf` follows undervoltage OR overvoltage without latching; undervoltage always raises `lockout_all`, overvoltage raises it only when `ov_lock_en` = 1.
- R8: A frame (`frame_done` pulse) with `frame_clr_req` = 1 clears all latched faults (overcurrent, underload, thermal shutdown) only if at least CLR_GAP_CYC cycles have passed since the previous frame; otherwise the request is ignored.
- R9: The enable pin low clears all latched faults and their outputs.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| en_pin | input | 1 | Enable pin level (asynchronous) |
| oc_flag | input | NUM_BRIDGES | Overcurrent comparator flags |
| ul_flag | input | NUM_BRIDGES | Low-side underload comparator flags |
| tw_flag | input | NUM_BRIDGES | Thermal warning flags |
| tsd_flag | input | NUM_BRIDGES | Thermal shutdown flags |
| uv_flag | input | 1 | Supply undervoltage flag |
| ov_flag | input | 1 | Supply overvoltage flag |
| frame_done | input | 1 | One-cycle pulse: a valid serial frame completed |
| frame_clr_req | input | 1 | Status-reset bit of that frame |
| ov_lock_en | input | 1 | Overvoltage lockout enable command bit |
| ul_shut_en | input | 1 | Underload shutdown enable command bit |
| bridge_off | output | NUM_BRIDGES | Per-bridge latch-off requests |
| lockout_all | output | 1 | Global lockout of all drivers |
| stat_oc | output | 1 | Latched overcurrent status |
| stat_ul | output | 1 | Latched underload status |
| stat_tsd | output | 1 | Latched thermal shutdown status |
| stat_tw | output | 1 | Live thermal warning status |
| stat_psf | output | 1 | Live supply-fail status |

## Verification
Overcurrent is driven both as a pulse shorter than the qualification window and as a long hold, which separates a qualified fault from a glitch and places the latch edge inside a few cycles. Underload is tried with a second bridge joining a running timer, with a short gap that must reload the timer, and with shutdown disabled, telling a shared non-restarting timer apart from a restarting or free-running one. Clear requests are sent too soon after a frame, while the thermal condition persists, and properly spaced, and the supply flags are toggled with the lockout enable in both states.

// File: rtl/mdfs_pkg.sv
package mdfs_pkg;
   // Registered live status bits of the supervisor.
   typedef struct packed {
      logic tw;
      logic psf;
      logic lock;
   } live_status_t;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/mdfs_sync.sv
module mdfs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import mdfs_pkg::*;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
         $error("mdfs_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("mdfs_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mdfs_oc_qual.sv
module mdfs_oc_qual #(
   parameter int QUAL_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flag,
   output logic latched
);
   localparam int CW = $clog2(QUAL_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

   generate
      if (QUAL_CYC < 2) begin : g_bad_qual
         $error("mdfs_oc_qual: QUAL_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          lat;
   logic          qualified;

   assign qualified = flag && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         lat <= 1'b0;
      end else begin
         if (!flag)             cnt <= '0;
         else if (cnt != LAST)  cnt <= cnt + CW'(1);
         if (qualified)         lat <= 1'b1;
         else if (clr)          lat <= 1'b0;
      end
   end

   assign latched = lat;

   assert_latch_needs_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat) |-> $past(flag));
   assert_count_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/mdfs_ul_timer.sv
module mdfs_ul_timer #(
   parameter int NB     = 6,
   parameter int UL_CYC = 200
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hold_off,
   input  logic          shut_en,
   input  logic [NB-1:0] ul_flags,
   output logic          st_ul,
   output logic [NB-1:0] ul_off
);
   localparam int TW = $clog2(UL_CYC + 1);
   localparam logic [TW-1:0] LAST = TW'(UL_CYC - 1);

   generate
      if (UL_CYC < 2) begin : g_bad_delay
         $error("mdfs_ul_timer: UL_CYC must be at least 2");
      end
   endgenerate

   logic [TW-1:0] tmr;
   logic          any_ul;
   logic          expire;
   logic          st_q;

   assign any_ul = |ul_flags;
   assign expire = any_ul && !hold_off && (tmr == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr  <= '0;
         st_q <= 1'b0;
      end else begin
         if (!any_ul || hold_off || expire) tmr <= '0;
         else                               tmr <= tmr + TW'(1);
         if (expire)   st_q <= 1'b1;
         else if (clr) st_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < NB; i++) begin : g_br
      logic off_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                              off_q <= 1'b0;
         else if (expire && shut_en && ul_flags[i]) off_q <= 1'b1;
         else if (clr)                            off_q <= 1'b0;
      end
      assign ul_off[i] = off_q;
   end

   assign st_ul = st_q;

   assert_timer_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ul |=> (tmr == '0));
   assert_status_needs_underload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q) |-> $past(any_ul));
   assert_timer_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr <= LAST);
endmodule

// File: rtl/mdfs_clr_gate.sv
module mdfs_clr_gate #(
   parameter int GAP_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic frame_clr_req,
   output logic clr_ok
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam logic [GW-1:0] SAT = GW'(GAP_CYC);

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("mdfs_clr_gate: GAP_CYC must be at least 1");
      end
   endgenerate

   logic [GW-1:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              gap_cnt <= SAT;
      else if (frame_done)     gap_cnt <= '0;
      else if (gap_cnt != SAT) gap_cnt <= gap_cnt + GW'(1);
   end

   assign clr_ok = frame_done && frame_clr_req && (gap_cnt == SAT);

   assert_gap_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (gap_cnt == '0));
   assert_no_back_to_back_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok |-> !$past(frame_done));
endmodule

// File: rtl/mdrv_fault_supervisor.sv
module mdrv_fault_supervisor #(
   parameter int NUM_BRIDGES  = 6,
   parameter int SYNC_STAGES  = 2,
   parameter int OC_QUAL_CYC  = 64,
   parameter int UL_DELAY_CYC = 200,
   parameter int CLR_GAP_CYC  = 100
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_pin,
   input  logic [NUM_BRIDGES-1:0] oc_flag,
   input  logic [NUM_BRIDGES-1:0] ul_flag,
   input  logic [NUM_BRIDGES-1:0] tw_flag,
   input  logic [NUM_BRIDGES-1:0] tsd_flag,
   input  logic                   uv_flag,
   input  logic                   ov_flag,
   input  logic                   frame_done,
   input  logic                   frame_clr_req,
   input  logic                   ov_lock_en,
   input  logic                   ul_shut_en,
   output logic [NUM_BRIDGES-1:0] bridge_off,
   output logic                   lockout_all,
   output logic                   stat_oc,
   output logic                   stat_ul,
   output logic                   stat_tsd,
   output logic                   stat_tw,
   output logic                   stat_psf
);
   import mdfs_pkg::*;

   localparam int NB = NUM_BRIDGES;
   localparam int SW = 4 * NB + 3;

   generate
      if (NB < 1) begin : g_bad_bridges
         $error("mdrv_fault_supervisor: NUM_BRIDGES must be positive");
      end
   endgenerate

   // Resynchronize every asynchronous flag in one bank.
   logic [SW-1:0] raw_bus, syn_bus;
   logic [NB-1:0] s_oc, s_ul, s_tw, s_tsd;
   logic          s_uv, s_ov, s_en;

   assign raw_bus = {en_pin, uv_flag, ov_flag, tsd_flag, tw_flag, ul_flag, oc_flag};

   mdfs_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus));

   assign {s_en, s_uv, s_ov, s_tsd, s_tw, s_ul, s_oc} = syn_bus;

   // Clear of latched faults.
   logic clr_ok, clr_all;

   mdfs_clr_gate #(.GAP_CYC(CLR_GAP_CYC)) i_clr_gate (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
      .frame_clr_req(frame_clr_req), .clr_ok(clr_ok));

   assign clr_all = clr_ok || !s_en;

   // Per-bridge overcurrent qualification and thermal shutdown latches.
   logic [NB-1:0] oc_lat, tsd_lat, ul_off;

   for (genvar i = 0; i < NB; i++) begin : g_bridge
      mdfs_oc_qual #(.QUAL_CYC(OC_QUAL_CYC)) i_oc_qual (
         .clk(clk), .rst_n(rst_n), .clr(clr_all), .flag(s_oc[i]),
         .latched(oc_lat[i]));

      logic tsd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          tsd_q <= 1'b0;
         else if (s_tsd[i])   tsd_q <= 1'b1;
         else if (clr_all)    tsd_q <= 1'b0;
      end
      assign tsd_lat[i] = tsd_q;

      assert_tsd_held_while_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (tsd_q && s_tsd[i]) |=> tsd_q);
   end

   // Shared underload timer.
   mdfs_ul_timer #(.NB(NB), .UL_CYC(UL_DELAY_CYC)) i_ul_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .hold_off(!s_en),
      .shut_en(ul_shut_en), .ul_flags(s_ul), .st_ul(stat_ul), .ul_off(ul_off));

   // Live (unlatched) status and global lockout.
   live_status_t live_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
      end else begin
         live_q.tw   <= |s_tw;
         live_q.psf  <= s_uv || s_ov;
         live_q.lock <= s_uv || (s_ov && ov_lock_en);
      end
   end

   assign bridge_off  = oc_lat | tsd_lat | ul_off;
   assign lockout_all = live_q.lock;
   assign stat_oc     = |oc_lat;
   assign stat_tsd    = |tsd_lat;
   assign stat_tw     = live_q.tw;
   assign stat_psf    = live_q.psf;

   assert_uv_forces_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_uv |=> lockout_all);
   assert_ov_free_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ov && !s_uv && !ov_lock_en) |=> !lockout_all);
   assert_enable_low_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_en && $past(!s_en) && !(|s_tsd) && !(|s_oc)) |-> (stat_oc == 1'b0));
endmodule

// File: tb/test_mdrv_fault_supervisor.sv
`timescale 1ns/1ps
module test_mdrv_fault_supervisor;
   localparam int NB   = 6;
   localparam int OCQ  = 64;
   localparam int ULD  = 200;
   localparam int GAP  = 100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_pin = 1'b1;
   logic [NB-1:0] oc_flag = '0, ul_flag = '0, tw_flag = '0, tsd_flag = '0;
   logic          uv_flag = 1'b0, ov_flag = 1'b0;
   logic          frame_done = 1'b0, frame_clr_req = 1'b0;
   logic          ov_lock_en = 1'b1, ul_shut_en = 1'b1;
   logic [NB-1:0] bridge_off;
   logic          lockout_all, stat_oc, stat_ul, stat_tsd, stat_tw, stat_psf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mdrv_fault_supervisor #(
      .NUM_BRIDGES(NB), .SYNC_STAGES(2), .OC_QUAL_CYC(OCQ),
      .UL_DELAY_CYC(ULD), .CLR_GAP_CYC(GAP)
   ) i_mdrv_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .oc_flag(oc_flag),
      .ul_flag(ul_flag), .tw_flag(tw_flag), .tsd_flag(tsd_flag),
      .uv_flag(uv_flag), .ov_flag(ov_flag), .frame_done(frame_done),
      .frame_clr_req(frame_clr_req), .ov_lock_en(ov_lock_en),
      .ul_shut_en(ul_shut_en), .bridge_off(bridge_off),
      .lockout_all(lockout_all), .stat_oc(stat_oc), .stat_ul(stat_ul),
      .stat_tsd(stat_tsd), .stat_tw(stat_tw), .stat_psf(stat_psf));

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send_frame(input logic clr);
      frame_done    = 1'b1;
      frame_clr_req = clr;
      wait_cyc(1);
      frame_done    = 1'b0;
      frame_clr_req = 1'b0;
      wait_cyc(2);
   endtask

   task automatic t_reset;
      check("R10 bridge_off", 32'(bridge_off), 0);
      check("R10 status", {26'd0, lockout_all, stat_oc, stat_ul, stat_tsd, stat_tw, stat_psf}, 0);
   endtask

   task automatic t_oc;
      oc_flag[1] = 1'b1;
      wait_cyc(30);
      oc_flag[1] = 1'b0;
      wait_cyc(10);
      check("R1 short pulse bridge_off", 32'(bridge_off), 0);
      check("R1 short pulse stat_oc", 32'(stat_oc), 0);
      oc_flag[2] = 1'b1;
      wait_cyc(OCQ - 2);
      check("R1 before window", 32'(bridge_off), 0);
      wait_cyc(8);
      check("R1 after window bridge_off", 32'(bridge_off), 32'h04);
      check("R1 after window stat_oc", 32'(stat_oc), 1);
      oc_flag[2] = 1'b0;
      wait_cyc(5);
      send_frame(1'b1);
      check("R8 spaced clear", 32'(bridge_off), 0);
      check("R8 spaced clear stat_oc", 32'(stat_oc), 0);
   endtask

   task automatic t_gap;
      oc_flag[0] = 1'b1;
      wait_cyc(OCQ + 6);
      oc_flag[0] = 1'b0;
      wait_cyc(4);
      send_frame(1'b0);
      wait_cyc(3);
      send_frame(1'b1);
      check("R8 early clear ignored", 32'(bridge_off), 32'h01);
      wait_cyc(GAP + 5);
      send_frame(1'b1);
      check("R8 late clear accepted", 32'(bridge_off), 0);
   endtask

   task automatic t_ul_shared;
      ul_shut_en = 1'b1;
      ul_flag[3] = 1'b1;
      wait_cyc(100);
      ul_flag[4] = 1'b1;
      wait_cyc(60);
      check("R2 before expiry", 32'(stat_ul), 0);
      wait_cyc(50);
      check("R2 shared expiry stat_ul", 32'(stat_ul), 1);
      check("R4 both bridges off", 32'(bridge_off), 32'h18);
      ul_flag = '0;
      wait_cyc(GAP);
      send_frame(1'b1);
      check("R8 underload cleared", {30'd0, stat_ul, |bridge_off}, 0);
   endtask

   task automatic t_ul_noshut;
      ul_shut_en = 1'b0;
      ul_flag[0] = 1'b1;
      wait_cyc(ULD + 10);
      check("R4 no shutdown stat_ul", 32'(stat_ul), 1);
      check("R4 no shutdown bridge_off", 32'(bridge_off), 0);
      ul_flag = '0;
      ul_shut_en = 1'b1;
      wait_cyc(GAP);
      send_frame(1'b1);
      check("R8 stat_ul cleared", 32'(stat_ul), 0);
   endtask

   task automatic t_ul_reload;
      ul_flag[5] = 1'b1;
      wait_cyc(150);
      ul_flag[5] = 1'b0;
      wait_cyc(10);
      ul_flag[5] = 1'b1;
      wait_cyc(150);
      check("R3 timer reloaded", 32'(stat_ul), 0);
      wait_cyc(65);
      check("R3 full delay then expiry", 32'(stat_ul), 1);
      check("R4 bridge 5 off", 32'(bridge_off), 32'h20);
      ul_flag = '0;
      wait_cyc(GAP);
      send_frame(1'b1);
      check("R8 reload case cleared", 32'(bridge_off), 0);
   endtask

   task automatic t_tw;
      tw_flag[2] = 1'b1;
      wait_cyc(5);
      check("R5 warning set", 32'(stat_tw), 1);
      check("R5 warning no latch-off", 32'(bridge_off), 0);
      tw_flag[2] = 1'b0;
      wait_cyc(5);
      check("R5 warning self-clears", 32'(stat_tw), 0);
   endtask

   task automatic t_tsd;
      tsd_flag[1] = 1'b1;
      wait_cyc(5);
      check("R6 tsd latch-off", 32'(bridge_off), 32'h02);
      check("R6 stat_tsd", 32'(stat_tsd), 1);
      wait_cyc(GAP + 5);
      send_frame(1'b1);
      check("R6 clear while hot ignored", 32'(stat_tsd), 1);
      tsd_flag[1] = 1'b0;
      wait_cyc(GAP + 5);
      send_frame(1'b1);
      check("R6 clear after cool-down", {30'd0, stat_tsd, |bridge_off}, 0);
   endtask

   task automatic t_supply;
      ov_lock_en = 1'b0;
      ov_flag = 1'b1;
      wait_cyc(5);
      check("R7 ov psf", 32'(stat_psf), 1);
      check("R7 ov no lockout when disabled", 32'(lockout_all), 0);
      ov_lock_en = 1'b1;
      wait_cyc(3);
      check("R7 ov lockout when enabled", 32'(lockout_all), 1);
      ov_flag = 1'b0;
      wait_cyc(5);
      check("R7 ov recovered", {30'd0, stat_psf, lockout_all}, 0);
      ov_lock_en = 1'b0;
      uv_flag = 1'b1;
      wait_cyc(5);
      check("R7 uv lockout always", {30'd0, stat_psf, lockout_all}, 3);
      uv_flag = 1'b0;
      ov_lock_en = 1'b1;
      wait_cyc(5);
      check("R7 uv recovered", {30'd0, stat_psf, lockout_all}, 0);
   endtask

   task automatic t_enable;
      oc_flag[5] = 1'b1;
      wait_cyc(OCQ + 6);
      oc_flag[5] = 1'b0;
      check("R9 oc latched before enable drop", 32'(bridge_off), 32'h20);
      en_pin = 1'b0;
      wait_cyc(5);
      check("R9 enable low clears", {30'd0, stat_oc, |bridge_off}, 0);
      en_pin = 1'b1;
      wait_cyc(5);
   endtask

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);
      t_reset();
      t_oc();
      t_gap();
      t_ul_shared();
      t_ul_noshut();
      t_ul_reload();
      t_tw();
      t_tsd();
      t_supply();
      t_enable();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule